// File: doc/BRIEF.md
# I2C Serial Memory Read Target

This block is a synchronous I2C target that answers reads from a 2 KiB byte array, organised as eight 256-byte blocks. It watches already-synchronised, oversampled SCL and SDA samples and finds START and STOP conditions and clock edges. It drives the bus only through an open-drain pull-down enable.

An 11-bit pointer is built from the three block bits of a write-direction control byte and the word address that follows it. The pointer persists between transactions.

The block supports three kinds of read:
- A current-address read continues from the pointer.
- A random read sets the pointer with an address-only write, then turns the bus around with a repeated START.
- A sequential read keeps streaming bytes for as long as the master acknowledges them. It wraps from the top of the array to address zero.

A backdoor write port fills the array for tests.

Top module: `i2c_eeprom_rd`

## Requirements
- R1: After reset the SDA pull-down enable is low and the pointer is 0, so a first current-address read returns byte 0.
- R2: A control byte whose bits 7:4 are 1010 is acknowledged by pulling SDA low for the whole ninth clock; bits 3:1 are the block bits and bit 0 is the direction (1 = read).
- R3: After a write-direction control byte, the next byte is a word address. The target acknowledges it and loads the pointer with {block bits, word address}; no array byte changes.
- R4: A repeated START right after the address acknowledge is followed by an accepted read control byte, whose first data byte comes from the newly loaded pointer.
- R5: Data bytes leave MSB first, and the SDA enable changes only in the cycle after an SCL falling edge, START or STOP.
- R6: A read control byte ignores its own block bits and reads from the pointer.
- R7: After a data byte, a master NACK followed by STOP leaves SDA released and the target idle.
- R8: A master ACK after a data byte makes the target send the next byte. The pointer rises by one per byte sent and wraps from 0x7FF to 0x000.
- R9: A control byte whose bits 7:4 are not 1010 gets no acknowledge and leaves the pointer unchanged. The target stays silent until the next START.
- R10: A START or STOP seen in the middle of a byte aborts that byte and clears the bit count. A START then begins a fresh control byte.
- R11: A backdoor write stores its byte at its address, and a later read returns it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample (resolved bus) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| bd_we_i | input | 1 | Backdoor write strobe |
| bd_addr_i | input | 11 | Backdoor byte address |
| bd_data_i | input | 8 | Backdoor write data |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except when it forms a START or STOP. They also assume that each SCL phase lasts several system clocks, so the enable change one cycle after a falling edge still lands inside the low phase. The bench master holds every quarter bit for four clocks, and it moves SDA only while SCL is low. A per-clock monitor flags any pull-down during an SCL high phase in which the bench has not granted the target a bit.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 8;
  localparam int BLK_W  = 3;
  localparam logic [3:0] TYPE_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_CACK, ST_ADDR, ST_AACK, ST_SKIP, ST_TX, ST_TACK
  } tgt_state_e;

  // next pointer, wraps at the array end by width truncation
  function automatic logic [ADDR_W-1:0] ptr_next(input logic [ADDR_W-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic type_ok(input logic [DATA_W-1:0] b);
    return b[DATA_W-1 -: 4] == TYPE_CODE;
  endfunction
endpackage

// File: rtl/i2c_cond_det.sv
module i2c_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_rd_mem.sv
module i2c_rd_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_rd_fsm.sv
module i2c_rd_fsm
  import i2c_rd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int BW = BLK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          sda_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          sda_oe_o
);
  localparam int CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DW);

  tgt_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0]  sh_q;
  logic [AW-1:0]  ptr_q;
  logic [BW-1:0]  blk_q;
  logic           rw_q, mack_q, oe_q;

  // named internal events for the assertions
  logic byte_end_w, reject_w, addr_load_w;
  assign byte_end_w  = scl_fall_i && cnt_q == FULL;
  assign reject_w    = state_q == ST_CTRL && byte_end_w && !type_ok(sh_q) && !start_i && !stop_i;
  assign addr_load_w = state_q == ST_ADDR && byte_end_w && !start_i && !stop_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      blk_q   <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_CTRL;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_CTRL, ST_ADDR: begin
          if (scl_rise_i && cnt_q != FULL) begin
            sh_q  <= {sh_q[DW-2:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
          end else if (byte_end_w) begin
            cnt_q <= '0;
            if (state_q == ST_ADDR) begin
              ptr_q   <= {blk_q, sh_q[AW-BW-1:0]};
              oe_q    <= 1'b1;
              state_q <= ST_AACK;
            end else if (type_ok(sh_q)) begin
              blk_q   <= sh_q[BW:1];
              rw_q    <= sh_q[0];
              oe_q    <= 1'b1;
              state_q <= ST_CACK;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_CACK: if (scl_fall_i) begin
          if (rw_q) begin
            sh_q    <= rd_data_i;
            oe_q    <= ~rd_data_i[DW-1];
            cnt_q   <= CNT_W'(1);
            state_q <= ST_TX;
          end else begin
            oe_q    <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_ADDR;
          end
        end
        ST_AACK: if (scl_fall_i) begin
          oe_q    <= 1'b0;
          state_q <= ST_SKIP;
        end
        ST_TX: if (scl_fall_i) begin
          if (cnt_q == FULL) begin
            oe_q    <= 1'b0;
            ptr_q   <= ptr_next(ptr_q);
            state_q <= ST_TACK;
          end else begin
            oe_q  <= ~sh_q[DW-2];
            sh_q  <= {sh_q[DW-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_TACK: begin
          if (scl_rise_i) mack_q <= ~sda_i;
          else if (scl_fall_i) begin
            if (mack_q) begin
              sh_q    <= rd_data_i;
              oe_q    <= ~rd_data_i[DW-1];
              cnt_q   <= CNT_W'(1);
              state_q <= ST_TX;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_addr_o = ptr_q;
  assign sda_oe_o  = oe_q;

  // R5
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> $past(scl_fall_i || start_i || stop_i));

  // R8
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q != $past(ptr_q)) |-> (ptr_q == ptr_next($past(ptr_q)) || $past(addr_load_w)));

  // R10
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (state_q == ST_CTRL && cnt_q == '0 && !oe_q));

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!oe_q && state_q == ST_IDLE));

  // R9
  reject_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_w |=> (!oe_q && state_q == ST_IDLE && $stable(ptr_q)));
endmodule

// File: rtl/i2c_eeprom_rd.sv
module i2c_eeprom_rd
  import i2c_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              bd_we_i,
  input  logic [ADDR_W-1:0] bd_addr_i,
  input  logic [DATA_W-1:0] bd_data_i
);
  logic scl_rise_w, scl_fall_w, start_w, stop_w;
  logic [ADDR_W-1:0] rd_addr_w;
  logic [DATA_W-1:0] rd_data_w;

  i2c_cond_det u_det (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise_o(scl_rise_w), .scl_fall_o(scl_fall_w),
    .start_o(start_w), .stop_o(stop_w)
  );

  i2c_rd_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk(clk), .we_i(bd_we_i), .waddr_i(bd_addr_i), .wdata_i(bd_data_i),
    .raddr_i(rd_addr_w), .rdata_o(rd_data_w)
  );

  i2c_rd_fsm #(.AW(ADDR_W), .DW(DATA_W), .BW(BLK_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl_rise_i(scl_rise_w), .scl_fall_i(scl_fall_w),
    .start_i(start_w), .stop_i(stop_w), .sda_i(sda_i),
    .rd_data_i(rd_data_w), .rd_addr_o(rd_addr_w), .sda_oe_o(sda_oe_o)
  );
endmodule

// File: tb/i2c_eeprom_rd_tb_top.sv
module i2c_eeprom_rd_tb_top;
  localparam int Q = 4;
  localparam int NBYTES = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  logic bd_we = 1'b0;
  logic [10:0] bd_addr = '0;
  logic [7:0]  bd_data = '0;
  wire  sda_bus = m_sda & ~sda_oe;

  int checks = 0, errors = 0, viol = 0;
  bit slot = 1'b0;
  bit done = 1'b0;
  int mp;
  logic [7:0] model [NBYTES];

  always #5 clk = ~clk;

  i2c_eeprom_rd dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .bd_we_i(bd_we), .bd_addr_i(bd_addr), .bd_data_i(bd_data)
  );

  // per-clock monitor: no pull-down while SCL high outside a granted slot (R5)
  always @(negedge clk) if (rst_n && m_scl && !slot && sda_oe) viol++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37) + ((i >> 8) * 11) + 3);
  endfunction

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic m_start();
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic m_stop();
    m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; qw();
  endtask

  task automatic wbit(input logic b);
    m_sda = b; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
  endtask

  task automatic rbit(output logic b);
    m_sda = 1'b1; slot = 1'b1; qw(); m_scl = 1'b1; qw(); b = sda_bus; qw();
    m_scl = 1'b0; qw(); slot = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
    wbit(~mack);
  endtask

  task automatic cur_read(input logic [7:0] ctrl, input string req);
    logic a; logic [7:0] d;
    m_start();
    send_byte(ctrl, a); chk({req, " ctrl ack"}, a, 1);
    recv_byte(1'b0, d); chk({req, " data"}, d, model[mp]);
    mp = (mp + 1) % NBYTES;
    m_stop(); qw();
    chk({req, " released after stop (R7)"}, sda_oe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic a; logic [7:0] d;
    repeat (4) @(negedge clk);
    chk("R1 oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    // R11 backdoor preload
    for (int i = 0; i < NBYTES; i++) begin
      model[i] = pat(i);
      bd_we = 1'b1; bd_addr = 11'(i); bd_data = pat(i);
      @(negedge clk);
    end
    bd_we = 1'b0;
    mp = 0;
    chk("R1 oe idle", sda_oe, 0);

    // R1 first current read returns byte 0; R2 control ack
    cur_read(8'hA1, "R1 R2");

    // R3 R4 R6 random read of 0x123, read control carries block 0
    m_start();
    send_byte(8'hA2, a); chk("R2 write ctrl ack", a, 1);
    send_byte(8'h23, a); chk("R3 addr ack", a, 1);
    m_start();
    send_byte(8'hA1, a); chk("R4 read ctrl ack after restart", a, 1);
    mp = 11'h123;
    recv_byte(1'b0, d); chk("R4 R6 random data", d, model[mp]);
    mp = mp + 1;
    m_stop(); qw();

    // R6 block bits of read control ignored
    cur_read(8'hAB, "R6 current read blk5");

    // R9 foreign control code
    m_start();
    send_byte(8'hB1, a); chk("R9 foreign code no ack", a, 0);
    for (int i = 0; i < 9; i++) begin wbit(1'b1); chk("R9 silent", sda_oe, 0); end
    m_stop();
    cur_read(8'hA1, "R9 pointer kept");

    // R10 STOP mid-byte, then START mid-byte
    m_start(); wbit(1); wbit(0); wbit(1); m_stop(); qw();
    chk("R10 idle after mid stop", sda_oe, 0);
    m_start(); wbit(1); wbit(0); wbit(1); wbit(0); wbit(0);
    cur_read(8'hA1, "R10 restart mid-byte");

    // R8 sequential 300 bytes from 0x76E across the wrap
    m_start();
    send_byte(8'hAE, a); chk("R8 write ctrl ack", a, 1);
    send_byte(8'h6E, a); chk("R8 addr ack", a, 1);
    m_start();
    send_byte(8'hA1, a); chk("R8 read ctrl ack", a, 1);
    mp = 11'h76E;
    for (int i = 0; i < 300; i++) begin
      recv_byte(i != 299, d);
      chk("R8 sequential data", d, model[mp]);
      mp = (mp + 1) % NBYTES;
    end
    m_stop(); qw();
    chk("R8 pointer after wrap", mp, 11'h09A);
    cur_read(8'hA1, "R8 current after wrap");

    // R11 backdoor overwrite seen by a read
    @(negedge clk); bd_we = 1'b1; bd_addr = 11'h09B; bd_data = 8'h5A;
    @(negedge clk); bd_we = 1'b0; model[11'h09B] = 8'h5A;
    cur_read(8'hA1, "R11 backdoor byte");

    chk("R5 no drive outside slots", viol, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule